// File: doc/BRIEF.md
# USB Speed Fallback Sequencer

This block steers the connect sequence of a USB device that should come up at SuperSpeed when the host side allows it, and otherwise settle for high-speed. Once bus power is present, it asks the USB controller to connect with SuperSpeed enabled and starts a millisecond timeout. The timeout length is given by a configuration input. If the host issues a set-configuration before the timeout runs out, the timer is abandoned and the link stays at SuperSpeed.

If the timeout expires first, the sequencer drops the connection. The disconnect still carries the SuperSpeed flag. The sequencer then waits a fixed delay and connects again with SuperSpeed disabled, which leaves the device at USB 2.0 speed. Time is measured in pulses of an external 1 ms tick.

A host reset or a loss of bus power sends the sequencer back to its idle state from any step. It restarts on the next cycle in which power is present and no reset is asserted.

Top module: `usb_speed_fallback_seq`

## Requirements
- R1: After reset, conn_req_o is 0, ss_en_o is 1, done_ss_o is 0 and done_hs_o is 0.
- R2: In idle, with vbus_i high and host_reset_i low, conn_req_o rises on the next cycle with ss_en_o at 1. It stays high while the sequencer waits for set-configuration.
- R3: During the SuperSpeed wait, the timer counts tick_i pulses. Once it has counted to_ms_i pulses, the next cycle drops conn_req_o. A value of 0 times out on the first wait cycle.
- R4: A set_cfg_i pulse during the SuperSpeed wait, before expiry, raises done_ss_o on the next cycle with conn_req_o and ss_en_o at 1. Later ticks do not change this.
- R5: A set_cfg_i pulse in the same cycle in which the timeout is reached counts as success, giving done_ss_o instead of a disconnect.
- R6: The first cycle of the disconnect shows conn_req_o at 0 with ss_en_o still at 1.
- R7: After that cycle, ss_en_o drops to 0 and conn_req_o stays 0 for DELAY_MS tick_i pulses. The cycle after the last of these raises conn_req_o with ss_en_o at 0. The cycle after that raises done_hs_o.
- R8: host_reset_i high or vbus_i low in any state gives idle outputs (conn_req_o 0, ss_en_o 1, both done flags 0) on the next cycle.
- R9: ss_en_o only changes in a cycle in which conn_req_o is 0.
- R10: to_ms_i is captured in the first connect cycle. Changes to it during the wait do not move the timeout.
- R11: set_cfg_i outside the SuperSpeed wait is ignored: it does not shorten the delay and does not change a finished state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| vbus_i | input | 1 | Bus power present (low means cable detached) |
| host_reset_i | input | 1 | Host reset seen on the bus |
| set_cfg_i | input | 1 | Set-configuration event strobe |
| to_ms_i | input | TO_W | SuperSpeed timeout in ticks |
| conn_req_o | output | 1 | Connect request level to the USB controller |
| ss_en_o | output | 1 | SuperSpeed enable flag sent with the request |
| done_ss_o | output | 1 | Enumerated at SuperSpeed |
| done_hs_o | output | 1 | Enumerated after fallback to USB 2.0 |

## Verification
The race that matters is a set-configuration strobe landing in the very cycle the timeout count is reached. The bench provokes it by issuing ticks by hand until the count equals the configured limit. It then drives set_cfg_i in that same cycle and expects done_ss_o, not a disconnect. A second collision, an abort arriving together with any other event, is judged against a behavioural reference model compared every clock, in which the abort takes priority.

// File: rtl/usbfb_pkg.sv
package usbfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SS_CONNECT = 3'd1,
    ST_SS_WAIT    = 3'd2,
    ST_DISCONNECT = 3'd3,
    ST_DELAY      = 3'd4,
    ST_HS_CONNECT = 3'd5,
    ST_DONE_SS    = 3'd6,
    ST_DONE_HS    = 3'd7
  } seq_state_e;
endpackage

// File: rtl/usbfb_tick_timer.sv
module usbfb_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (clear_i)                             cnt_q <= '0;
    else if (run_i && tick_i && cnt_q < limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= limit_i);  // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));  // R3
endmodule

// File: rtl/usbfb_seq_fsm.sv
module usbfb_seq_fsm
  import usbfb_pkg::*;
#(
  parameter int TO_W     = 16,
  parameter int CNT_W    = 16,
  parameter int DELAY_MS = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vbus_i,
  input  logic             host_reset_i,
  input  logic             set_cfg_i,
  input  logic [TO_W-1:0]  to_ms_i,
  input  logic             expired_i,
  output logic             tmr_clear_o,
  output logic             tmr_run_o,
  output logic [CNT_W-1:0] tmr_limit_o,
  output logic             conn_req_o,
  output logic             ss_en_o,
  output logic             done_ss_o,
  output logic             done_hs_o
);
  localparam logic [CNT_W-1:0] DelayLim = CNT_W'(DELAY_MS);

  seq_state_e       state_q, state_d;
  logic [TO_W-1:0]  to_q;
  logic             abort;

  assign abort = host_reset_i || !vbus_i;

  always_comb begin
    state_d = state_q;
    if (abort) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:       state_d = ST_SS_CONNECT;
        ST_SS_CONNECT: state_d = ST_SS_WAIT;
        ST_SS_WAIT: begin
          if (set_cfg_i)      state_d = ST_DONE_SS;  // success wins a tie
          else if (expired_i) state_d = ST_DISCONNECT;
        end
        ST_DISCONNECT: state_d = ST_DELAY;
        ST_DELAY:      if (expired_i) state_d = ST_HS_CONNECT;
        ST_HS_CONNECT: state_d = ST_DONE_HS;
        ST_DONE_SS:    state_d = ST_DONE_SS;
        ST_DONE_HS:    state_d = ST_DONE_HS;
        default:       state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      to_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SS_CONNECT) to_q <= to_ms_i;
    end
  end

  assign tmr_clear_o = (state_q == ST_SS_CONNECT) || (state_q == ST_DISCONNECT);
  assign tmr_run_o   = (state_q == ST_SS_WAIT) || (state_q == ST_DELAY);
  assign tmr_limit_o = (state_q == ST_DELAY) ? DelayLim : CNT_W'(to_q);

  always_comb begin
    conn_req_o = 1'b0;
    ss_en_o    = 1'b1;
    unique case (state_q)
      ST_SS_CONNECT, ST_SS_WAIT, ST_DONE_SS: conn_req_o = 1'b1;
      ST_DELAY:                              ss_en_o    = 1'b0;
      ST_HS_CONNECT, ST_DONE_HS: begin
        conn_req_o = 1'b1;
        ss_en_o    = 1'b0;
      end
      default: ;
    endcase
  end

  assign done_ss_o = (state_q == ST_DONE_SS);
  assign done_hs_o = (state_q == ST_DONE_HS);

  AST_SS_EN_DISCONNECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ss_en_o) |-> !conn_req_o);  // R9
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!conn_req_o && ss_en_o && !done_ss_o && !done_hs_o));  // R8
  AST_TIE_SUCCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SS_WAIT && set_cfg_i && !abort) |=> done_ss_o);  // R5
  AST_DISC_KEEPS_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(conn_req_o) && !$past(abort)) |-> ss_en_o);  // R6
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_ss_o, done_hs_o}));  // R4
endmodule

// File: rtl/usb_speed_fallback_seq.sv
module usb_speed_fallback_seq #(
  parameter int TO_W     = 16,
  parameter int DELAY_MS = 100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            vbus_i,
  input  logic            host_reset_i,
  input  logic            set_cfg_i,
  input  logic [TO_W-1:0] to_ms_i,
  output logic            conn_req_o,
  output logic            ss_en_o,
  output logic            done_ss_o,
  output logic            done_hs_o
);
  localparam int DLY_W = $clog2(DELAY_MS + 1);
  localparam int CNT_W = (TO_W > DLY_W) ? TO_W : DLY_W;

  logic             tmr_clear, tmr_run, tmr_expired;
  logic [CNT_W-1:0] tmr_limit;

  usbfb_seq_fsm #(
    .TO_W(TO_W), .CNT_W(CNT_W), .DELAY_MS(DELAY_MS)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vbus_i       (vbus_i),
    .host_reset_i (host_reset_i),
    .set_cfg_i    (set_cfg_i),
    .to_ms_i      (to_ms_i),
    .expired_i    (tmr_expired),
    .tmr_clear_o  (tmr_clear),
    .tmr_run_o    (tmr_run),
    .tmr_limit_o  (tmr_limit),
    .conn_req_o   (conn_req_o),
    .ss_en_o      (ss_en_o),
    .done_ss_o    (done_ss_o),
    .done_hs_o    (done_hs_o)
  );

  usbfb_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tmr_clear),
    .run_i     (tmr_run),
    .tick_i    (tick_i),
    .limit_i   (tmr_limit),
    .expired_o (tmr_expired)
  );
endmodule

// File: tb/tb_usb_speed_fallback_seq.sv
`timescale 1ns/1ps
module tb_usb_speed_fallback_seq;
  localparam int TO_W = 16;
  localparam int DLY  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, vbus = 1'b0, hrst = 1'b0, scfg = 1'b0;
  logic [TO_W-1:0] to_ms = '0;
  logic conn, ssen, dss, dhs;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  usb_speed_fallback_seq #(.TO_W(TO_W), .DELAY_MS(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vbus_i(vbus),
    .host_reset_i(hrst), .set_cfg_i(scfg), .to_ms_i(to_ms),
    .conn_req_o(conn), .ss_en_o(ssen), .done_ss_o(dss), .done_hs_o(dhs));

  // reference model: 0 idle,1 ss conn,2 ss wait,3 disc,4 delay,5 hs conn,6 done ss,7 done hs
  int m_st = 0, m_cnt = 0, m_to = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_to = 0;
    end else if (hrst || !vbus) m_st = 0;
    else begin
      case (m_st)
        0: m_st = 1;
        1: begin m_to = int'(to_ms); m_cnt = 0; m_st = 2; end
        2: if (scfg) m_st = 6;
           else if (m_cnt >= m_to) m_st = 3;
           else if (tick) m_cnt++;
        3: begin m_cnt = 0; m_st = 4; end
        4: if (m_cnt >= DLY) m_st = 5; else if (tick) m_cnt++;
        5: m_st = 7;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic e_conn, e_ss;
      e_conn = (m_st == 1 || m_st == 2 || m_st == 5 || m_st == 6 || m_st == 7);
      e_ss   = !(m_st == 4 || m_st == 5 || m_st == 7);
      checks++;
      if ({conn, ssen, dss, dhs} !== {e_conn, e_ss, m_st == 6, m_st == 7}) begin
        errors++;
        $display("FAIL model R2 R8 state %0d: got %b exp %b", m_st,
                 {conn, ssen, dss, dhs}, {e_conn, e_ss, m_st == 6, m_st == 7});
      end
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {conn,ss_en,done_ss,done_hs} got %b exp %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    #1;
  endtask

  task automatic pulse_cfg();
    @(negedge clk); scfg = 1'b1;
    @(negedge clk); scfg = 1'b0;
    #1;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      report();
    end
  end

  initial begin
    step(3);
    chk("R1 reset", {conn, ssen, dss, dhs}, 4'b0100);
    @(negedge clk); rst_n = 1'b1;
    step(2);
    chk("R1 idle no vbus", {conn, ssen, dss, dhs}, 4'b0100);

    // timeout path
    to_ms = 16'd5;
    @(negedge clk); vbus = 1'b1;
    step(1);
    chk("R2 ss connect", {conn, ssen, dss, dhs}, 4'b1100);
    step(1);
    ticks(4); step(1);
    chk("R3 before expiry", {conn, ssen, dss, dhs}, 4'b1100);
    ticks(1); step(1);
    chk("R6 disconnect keeps ss", {conn, ssen, dss, dhs}, 4'b0100);
    step(1);
    chk("R7 delay ss off", {conn, ssen, dss, dhs}, 4'b0000);
    ticks(50);
    pulse_cfg();
    chk("R11 cfg in delay", {conn, ssen, dss, dhs}, 4'b0000);
    ticks(49); step(1);
    chk("R7 delay not over", {conn, ssen, dss, dhs}, 4'b0000);
    ticks(1); step(1);
    chk("R7 hs connect", {conn, ssen, dss, dhs}, 4'b1000);
    step(1);
    chk("R7 done hs", {conn, ssen, dss, dhs}, 4'b1001);
    pulse_cfg();
    chk("R11 cfg after done", {conn, ssen, dss, dhs}, 4'b1001);

    // host reset, then success path
    @(negedge clk); hrst = 1'b1;
    @(negedge clk); hrst = 1'b0; #1;
    chk("R8 host reset", {conn, ssen, dss, dhs}, 4'b0100);
    step(1);
    chk("R2 restart", {conn, ssen, dss, dhs}, 4'b1100);
    step(1);
    ticks(2);
    pulse_cfg();
    chk("R4 success", {conn, ssen, dss, dhs}, 4'b1110);
    ticks(10);
    chk("R4 timer stopped", {conn, ssen, dss, dhs}, 4'b1110);
    @(negedge clk); vbus = 1'b0;
    step(1);
    chk("R8 detach", {conn, ssen, dss, dhs}, 4'b0100);

    // tie: set-config in the expiry cycle
    to_ms = 16'd3;
    @(negedge clk); vbus = 1'b1;
    step(2);
    ticks(3);
    scfg = 1'b1;
    @(negedge clk); scfg = 1'b0; #1;
    chk("R5 tie is success", {conn, ssen, dss, dhs}, 4'b1110);
    @(negedge clk); vbus = 1'b0;
    step(1);

    // timeout captured at connect
    to_ms = 16'd4;
    @(negedge clk); vbus = 1'b1;
    step(2);
    to_ms = 16'd200;
    ticks(4); step(1);
    chk("R10 latched timeout", {conn, ssen, dss, dhs}, 4'b0100);
    @(negedge clk); vbus = 1'b0;
    step(1);

    // zero timeout
    to_ms = 16'd0;
    @(negedge clk); vbus = 1'b1;
    step(2);
    chk("R3 zero wait cycle", {conn, ssen, dss, dhs}, 4'b1100);
    step(1);
    chk("R3 zero timeout", {conn, ssen, dss, dhs}, 4'b0100);
    step(1);
    chk("R9 ss flips while off", {conn, ssen, dss, dhs}, 4'b0000);
    @(negedge clk); vbus = 1'b0;
    step(2);

    finished = 1;
    report();
  end
endmodule